// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block is the control state machine that sits between a volatile memory array and its nonvolatile shadow. It decides when the array contents are saved (store) and when they are reloaded (recall). It issues the erase, program, clear and transfer phase strobes, and it gates array reads and writes while an operation is running. A store can be requested by a software command, by an external source pulling the shared active-low busy pin low, or by a supply-fail indication. A recall can be requested by a software command, and it also runs on its own whenever the supply comes back above its threshold, including at power-up, which the asynchronous reset represents.

The busy pin is bidirectional. The block samples its level as a request input. It also has two drive enables: a pull-low enable and a strong-high enable. When neither is active, only a weak pull-up holds the pin. A write latch records whether the array changed since the last completed operation, and pin-requested and supply-fail stores are skipped while that latch is clear. The supply threshold arrives as a digital comparator level. Every phase length is a parameter in clock cycles, and a one-cycle done pulse marks the end of each store or recall.

Top module: `nv_sequencer`

## Requirements
- R1: The write latch is set by every write the block accepts (`wr_req_i` high while `wr_inhibit_o` is low). It is cleared when a store completes its program phase or a recall completes its transfer phase.
- R2: A software store always runs. A store requested by the pin or by supply loss runs only if the write latch is set.
- R3: A pin-requested or supply-fail store begins with a grace phase of GRACE_CYC cycles, with busy driven low, before the erase phase starts.
  - A write that was accepted in the cycle before entry, and whose `wr_req_i` stays high, keeps being accepted during the grace phase.
  - Any other write is inhibited from the cycle the pin reads low.
- R4: If the pin reads low while the write latch is clear, the block does not drive busy. It inhibits all reads and writes until the pin reads high again.
- R5: Busy is driven low for the whole of a store. After the program phase ends, busy is driven strongly high for HOLD_CYC cycles, then left undriven. The two drive enables are never active together.
- R6: A store runs an erase phase of ERASE_CYC cycles, then a program phase of PROG_CYC cycles. `erase_o` pulses in the first cycle of the erase phase, and `program_o` pulses in the first cycle of the program phase.
- R7: Every store and recall is followed by a settling phase of SETTLE_CYC cycles with reads and writes inhibited. `done_o` pulses for one cycle in the first cycle back in idle.
- R8: Reset, and any supply loss that finds no store to perform, enter a low-supply wait. When `vcc_ok_i` is high in that wait, a recall starts with busy driven low.
- R9: A recall runs a clear phase of CLEAR_CYC cycles, then a transfer phase of XFER_CYC cycles. `clear_o` and `transfer_o` pulse in the first cycle of each phase. A recall started by software does not drive busy.
- R10: Auto-store (`auto_en_o`) is 1 after reset, and the two software commands turn it off or on while the block is idle. The program phase of every store copies the live value into a saved copy, and the end of every recall reloads the live value from that copy. While auto-store is off, a supply loss never starts a store.
- R11: While `vcc_ok_i` is low, reads and writes are inhibited, apart from a write continued inside a grace phase. The pin and the software commands have no effect.
- R12: In idle, requests are taken in this order of priority:
  - supply low
  - pin low
  - software store
  - software recall
  - auto-store off, then auto-store on

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up) |
| vcc_ok_i | input | 1 | Supply comparator, 1 = above threshold |
| busy_pin_i | input | 1 | Sampled level of the shared busy pin, 0 = low |
| wr_req_i | input | 1 | Array write request |
| sw_store_i | input | 1 | Software store command pulse |
| sw_recall_i | input | 1 | Software recall command pulse |
| sw_auto_on_i | input | 1 | Software auto-store enable pulse |
| sw_auto_off_i | input | 1 | Software auto-store disable pulse |
| rd_inhibit_o | output | 1 | Array reads blocked |
| wr_inhibit_o | output | 1 | Array writes blocked |
| erase_o | output | 1 | Erase phase start strobe |
| program_o | output | 1 | Program phase start strobe |
| clear_o | output | 1 | Array clear phase start strobe |
| transfer_o | output | 1 | Shadow-to-array transfer phase start strobe |
| busy_drive_low_o | output | 1 | Pull the busy pin low |
| busy_drive_high_o | output | 1 | Drive the busy pin strongly high |
| done_o | output | 1 | One-cycle pulse at the end of a store or recall |
| auto_en_o | output | 1 | Live auto-store enable |

## Verification
Two pairs of events can land in the same cycle.

The first pair is a pin request and an array write that is still being held. The bench keeps `wr_req_i` high across the cycle in which it pulls the pin low, then drops the request and raises it again inside the grace phase. The reference model then expects the held write to be accepted and the fresh one to be refused.

The second pair is a pin request and a software store pulse given together. Here the bench expects the grace phase with busy low rather than an immediate erase strobe, and a single erase overall. A store pulse and a recall pulse given together must yield one erase and no clear.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_GRACE,
    ST_ERASE,
    ST_PROG,
    ST_HOLD,
    ST_SETTLE,
    ST_LOWV,
    ST_CLEAR,
    ST_XFER,
    ST_EXTH
  } seq_st_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nvseq_timer.sv
module nvseq_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/nvseq_wlatch.sv
module nvseq_wlatch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic dirty_o
);

  // clear wins: a completed operation supersedes a same-cycle write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dirty_o <= 1'b0;
    else if (clr_i)  dirty_o <= 1'b0;
    else if (set_i)  dirty_o <= 1'b1;
  end

endmodule

// File: rtl/nv_sequencer.sv
module nv_sequencer
  import nvseq_pkg::*;
#(
  parameter int unsigned GRACE_CYC  = 4,
  parameter int unsigned ERASE_CYC  = 16,
  parameter int unsigned PROG_CYC   = 16,
  parameter int unsigned HOLD_CYC   = 2,
  parameter int unsigned SETTLE_CYC = 8,
  parameter int unsigned CLEAR_CYC  = 4,
  parameter int unsigned XFER_CYC   = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vcc_ok_i,
  input  logic busy_pin_i,
  input  logic wr_req_i,
  input  logic sw_store_i,
  input  logic sw_recall_i,
  input  logic sw_auto_on_i,
  input  logic sw_auto_off_i,
  output logic rd_inhibit_o,
  output logic wr_inhibit_o,
  output logic erase_o,
  output logic program_o,
  output logic clear_o,
  output logic transfer_o,
  output logic busy_drive_low_o,
  output logic busy_drive_high_o,
  output logic done_o,
  output logic auto_en_o
);

  localparam int unsigned DMAX = umax(umax(umax(GRACE_CYC, ERASE_CYC), umax(PROG_CYC, HOLD_CYC)),
                                      umax(umax(SETTLE_CYC, CLEAR_CYC), XFER_CYC));
  localparam int unsigned CW   = $clog2(DMAX + 1);

  seq_st_e       st_q, st_d;
  logic          access_ok, wr_acc, dirty, tzero, enter;
  logic          gw_q, wacc_q, live_q, nv_q, pwr_q;
  logic [CW-1:0] dur;

  assign access_ok    = (st_q == ST_IDLE) && vcc_ok_i && busy_pin_i;
  assign rd_inhibit_o = !access_ok;
  assign wr_inhibit_o = !(access_ok || ((st_q == ST_GRACE) && gw_q));
  assign wr_acc       = wr_req_i && !wr_inhibit_o;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (!vcc_ok_i)        st_d = (live_q && dirty) ? ST_GRACE : ST_LOWV;
        else if (!busy_pin_i) st_d = dirty ? ST_GRACE : ST_EXTH;
        else if (sw_store_i)  st_d = ST_ERASE;
        else if (sw_recall_i) st_d = ST_CLEAR;
      end
      ST_GRACE:  if (tzero) st_d = ST_ERASE;
      ST_ERASE:  if (tzero) st_d = ST_PROG;
      ST_PROG:   if (tzero) st_d = ST_HOLD;
      ST_HOLD:   if (tzero) st_d = ST_SETTLE;
      ST_SETTLE: if (tzero) st_d = ST_IDLE;
      ST_LOWV:   if (vcc_ok_i) st_d = ST_CLEAR;
      ST_CLEAR:  if (tzero) st_d = ST_XFER;
      ST_XFER:   if (tzero) st_d = ST_SETTLE;
      ST_EXTH:   if (busy_pin_i) st_d = ST_IDLE;
      default:   st_d = ST_LOWV;
    endcase
  end

  assign enter = (st_d != st_q);

  always_comb begin
    unique case (st_d)
      ST_GRACE:  dur = CW'(GRACE_CYC - 1);
      ST_ERASE:  dur = CW'(ERASE_CYC - 1);
      ST_PROG:   dur = CW'(PROG_CYC - 1);
      ST_HOLD:   dur = CW'(HOLD_CYC - 1);
      ST_SETTLE: dur = CW'(SETTLE_CYC - 1);
      ST_CLEAR:  dur = CW'(CLEAR_CYC - 1);
      ST_XFER:   dur = CW'(XFER_CYC - 1);
      default:   dur = '0;
    endcase
  end

  nvseq_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (enter),
    .val_i  (dur),
    .zero_o (tzero)
  );

  nvseq_wlatch u_wlatch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (wr_acc),
    .clr_i   (((st_q == ST_PROG) || (st_q == ST_XFER)) && tzero),
    .dirty_o (dirty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_LOWV;
      gw_q       <= 1'b0;
      wacc_q     <= 1'b0;
      live_q     <= 1'b1;
      nv_q       <= 1'b1;
      pwr_q      <= 1'b1;
      erase_o    <= 1'b0;
      program_o  <= 1'b0;
      clear_o    <= 1'b0;
      transfer_o <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      st_q   <= st_d;
      wacc_q <= wr_acc;
      // a write counts as in progress only if it was accepted just before entry
      if (enter && st_d == ST_GRACE) gw_q <= wacc_q && wr_req_i;
      else                           gw_q <= gw_q && wr_req_i;
      if (enter && st_d == ST_CLEAR) pwr_q <= (st_q == ST_LOWV);
      if (st_q == ST_IDLE && !enter && access_ok) begin
        if (sw_auto_off_i)     live_q <= 1'b0;
        else if (sw_auto_on_i) live_q <= 1'b1;
      end
      if (st_q == ST_PROG && tzero) nv_q   <= live_q;
      if (st_q == ST_XFER && tzero) live_q <= nv_q;
      erase_o    <= enter && (st_d == ST_ERASE);
      program_o  <= enter && (st_d == ST_PROG);
      clear_o    <= enter && (st_d == ST_CLEAR);
      transfer_o <= enter && (st_d == ST_XFER);
      done_o     <= enter && (st_q == ST_SETTLE);
    end
  end

  assign busy_drive_low_o  = (st_q == ST_GRACE) || (st_q == ST_ERASE) || (st_q == ST_PROG) ||
                             (((st_q == ST_CLEAR) || (st_q == ST_XFER)) && pwr_q);
  assign busy_drive_high_o = (st_q == ST_HOLD);
  assign auto_en_o         = live_q;

endmodule

// File: rtl/nv_sequencer_chk.sv
module nv_sequencer_chk
  import nvseq_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input logic    vcc_ok_i,
  input logic    rd_inhibit_o,
  input logic    wr_inhibit_o,
  input logic    erase_o,
  input logic    program_o,
  input logic    clear_o,
  input logic    transfer_o,
  input logic    busy_drive_low_o,
  input logic    busy_drive_high_o,
  input logic    done_o,
  input seq_st_e st_q
);

  a_r5_drive_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_drive_low_o && busy_drive_high_o));

  a_r5_hold_after_program: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_drive_high_o) |-> $past(st_q) == ST_PROG);

  a_r6_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({erase_o, program_o, clear_o, transfer_o}));

  a_r6_program_after_erase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    program_o |-> $past(st_q) == ST_ERASE);

  a_r9_transfer_after_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    transfer_o |-> $past(st_q) == ST_CLEAR);

  a_r7_done_after_settle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(rd_inhibit_o) && $past(st_q) == ST_SETTLE);

  a_r4_ext_hold_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_EXTH |-> !busy_drive_low_o && rd_inhibit_o && wr_inhibit_o);

  a_r11_low_supply_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vcc_ok_i && st_q != ST_GRACE) |-> (wr_inhibit_o && rd_inhibit_o));

endmodule

bind nv_sequencer nv_sequencer_chk u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .vcc_ok_i          (vcc_ok_i),
  .rd_inhibit_o      (rd_inhibit_o),
  .wr_inhibit_o      (wr_inhibit_o),
  .erase_o           (erase_o),
  .program_o         (program_o),
  .clear_o           (clear_o),
  .transfer_o        (transfer_o),
  .busy_drive_low_o  (busy_drive_low_o),
  .busy_drive_high_o (busy_drive_high_o),
  .done_o            (done_o),
  .st_q              (st_q)
);

// File: tb/sim_nv_sequencer.sv
`timescale 1ns/1ps
module sim_nv_sequencer;

  localparam int G = 3, E = 4, P = 5, H = 2, S = 3, C = 2, X = 3;
  localparam int K_IDLE = 0, K_GRACE = 1, K_ERASE = 2, K_PROG = 3, K_HOLD = 4,
                 K_SETTLE = 5, K_LOWV = 6, K_CLEAR = 7, K_XFER = 8, K_EXTH = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vcc = 1'b1, ext_low = 1'b0, wr = 1'b0, sws = 1'b0, swr = 1'b0, ae = 1'b0, ad = 1'b0;
  logic rdi, wri, er, pg, cl, tr, bl, bh, dn, aen;
  wire  pin = !(ext_low || bl);

  always #10 clk = ~clk;

  nv_sequencer #(.GRACE_CYC(G), .ERASE_CYC(E), .PROG_CYC(P), .HOLD_CYC(H),
                 .SETTLE_CYC(S), .CLEAR_CYC(C), .XFER_CYC(X)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .vcc_ok_i(vcc), .busy_pin_i(pin), .wr_req_i(wr),
    .sw_store_i(sws), .sw_recall_i(swr), .sw_auto_on_i(ae), .sw_auto_off_i(ad),
    .rd_inhibit_o(rdi), .wr_inhibit_o(wri), .erase_o(er), .program_o(pg),
    .clear_o(cl), .transfer_o(tr), .busy_drive_low_o(bl), .busy_drive_high_o(bh),
    .done_o(dn), .auto_en_o(aen));

  int n_cmp = 0, n_bad = 0, cycles = 0;
  int cnt_e = 0, cnt_p = 0, cnt_c = 0, cnt_t = 0, cnt_d = 0, cnt_bl = 0;
  bit ended = 0;

  // ---------------- reference model ----------------
  int ms, ml;
  bit md, mlive, mnv, mpwr, mgw, mwacc, xe, xp, xc, xt, xd;

  function automatic bit m_ok();
    return ms == K_IDLE && vcc && pin;
  endfunction
  function automatic bit m_wrinh();
    return !(m_ok() || (ms == K_GRACE && mgw));
  endfunction
  function automatic int dur(int s);
    case (s)
      K_GRACE: return G;   K_ERASE: return E;  K_PROG: return P;
      K_HOLD: return H;    K_SETTLE: return S; K_CLEAR: return C;
      K_XFER: return X;    default: return 1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int ns;
    bit acc, fin;
    if (!rst_n) begin
      ms = K_LOWV; ml = 0; md = 0; mlive = 1; mnv = 1; mpwr = 1; mgw = 0; mwacc = 0;
      {xe, xp, xc, xt, xd} = '0;
    end else begin
      acc = wr && !m_wrinh();
      fin = (ml == 0);
      ns = ms;
      case (ms)
        K_IDLE:
          if (!vcc) ns = (mlive && md) ? K_GRACE : K_LOWV;
          else if (!pin) ns = md ? K_GRACE : K_EXTH;
          else if (sws) ns = K_ERASE;
          else if (swr) ns = K_CLEAR;
        K_GRACE:  if (fin) ns = K_ERASE;
        K_ERASE:  if (fin) ns = K_PROG;
        K_PROG:   if (fin) ns = K_HOLD;
        K_HOLD:   if (fin) ns = K_SETTLE;
        K_SETTLE: if (fin) ns = K_IDLE;
        K_LOWV:   if (vcc) ns = K_CLEAR;
        K_CLEAR:  if (fin) ns = K_XFER;
        K_XFER:   if (fin) ns = K_SETTLE;
        K_EXTH:   if (pin) ns = K_IDLE;
        default:  ns = K_LOWV;
      endcase
      if (ms == K_IDLE && ns == K_IDLE && vcc && pin) begin
        if (ad) mlive = 0;
        else if (ae) mlive = 1;
      end
      if (ms == K_PROG && fin) mnv = mlive;
      if (ms == K_XFER && fin) mlive = mnv;
      if (ns == K_GRACE && ms != K_GRACE) mgw = mwacc && wr;
      else mgw = mgw && wr;
      mwacc = acc;
      if ((ms == K_PROG || ms == K_XFER) && fin) md = 0;
      else if (acc) md = 1;
      if (ns == K_CLEAR && ms != K_CLEAR) mpwr = (ms == K_LOWV);
      xe = ns == K_ERASE && ms != K_ERASE;
      xp = ns == K_PROG && ms != K_PROG;
      xc = ns == K_CLEAR && ms != K_CLEAR;
      xt = ns == K_XFER && ms != K_XFER;
      xd = ms == K_SETTLE && ns == K_IDLE;
      ml = (ns != ms) ? dur(ns) - 1 : ((ml > 0) ? ml - 1 : 0);
      ms = ns;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      cycles++;
      chk("R11", "rd_inhibit", rdi, !m_ok());
      chk("R3", "wr_inhibit", wri, m_wrinh());
      chk("R5", "busy_low", bl, (ms == K_GRACE || ms == K_ERASE || ms == K_PROG ||
                                 ((ms == K_CLEAR || ms == K_XFER) && mpwr)));
      chk("R5", "busy_high", bh, ms == K_HOLD);
      chk("R6", "erase", er, xe);
      chk("R6", "program", pg, xp);
      chk("R9", "clear", cl, xc);
      chk("R9", "transfer", tr, xt);
      chk("R7", "done", dn, xd);
      chk("R10", "auto_en", aen, mlive);
      cnt_e += er; cnt_p += pg; cnt_c += cl; cnt_t += tr; cnt_d += dn; cnt_bl += bl;
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); #5; end
  endtask
  task automatic clr_cnt();
    cnt_e = 0; cnt_p = 0; cnt_c = 0; cnt_t = 0; cnt_d = 0; cnt_bl = 0;
  endtask
  task automatic finish_run();
    ended = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    // reset state: low-supply wait, auto-store on
    chk("R8", "reset rd_inhibit", rdi, 1);
    chk("R10", "reset auto_en", aen, 1);
    chk("R5", "reset busy_low", bl, 0);
    cyc(20);
    chk("R8", "power-up clear count", cnt_c, 1);
    chk("R9", "power-up transfer count", cnt_t, 1);
    chk("R7", "power-up done count", cnt_d, 1);

    // R3 / R1: held write across pin request, then a fresh write in grace
    clr_cnt();
    wr = 1; cyc(3);
    ext_low = 1; cyc(1);
    cyc(1);
    wr = 0; cyc(1);
    wr = 1; chk("R3", "fresh write in grace blocked", wri, 1); cyc(1);
    wr = 0; ext_low = 0; cyc(30);
    chk("R2", "dirty pin store erase count", cnt_e, 1);
    chk("R1", "dirty pin store program count", cnt_p, 1);

    // R4 / R1: latch cleared by the store, pin request is not honoured
    clr_cnt();
    ext_low = 1; cyc(3);
    chk("R4", "clean pin busy_low", bl, 0);
    chk("R4", "clean pin rd_inhibit", rdi, 1);
    cyc(3); ext_low = 0; cyc(10);
    chk("R1", "clean pin erase count", cnt_e, 0);

    // R2 / R6 / R7: software store with clean latch
    clr_cnt();
    sws = 1; cyc(1); sws = 0; cyc(30);
    chk("R2", "software store erase count", cnt_e, 1);
    chk("R6", "software store program count", cnt_p, 1);
    chk("R7", "software store done count", cnt_d, 1);

    // R9: software recall, no busy drive
    clr_cnt();
    swr = 1; cyc(1); swr = 0; cyc(20);
    chk("R9", "software recall clear count", cnt_c, 1);
    chk("R9", "software recall transfer count", cnt_t, 1);
    chk("R9", "software recall busy cycles", cnt_bl, 0);

    // R10: disable without manual store does not persist
    clr_cnt();
    ad = 1; cyc(1); ad = 0; cyc(1);
    chk("R10", "auto off live", aen, 0);
    wr = 1; cyc(1); wr = 0;
    vcc = 0; cyc(6);
    chk("R10", "auto off no power-fail store", cnt_e, 0);
    vcc = 1; cyc(20);
    chk("R10", "unsaved disable reverts", aen, 1);

    // R10: disable saved by a manual store persists
    clr_cnt();
    ad = 1; cyc(1); ad = 0; sws = 1; cyc(1); sws = 0; cyc(30);
    wr = 1; cyc(1); wr = 0;
    vcc = 0; cyc(6); vcc = 1; cyc(20);
    chk("R10", "saved disable persists", aen, 0);
    chk("R10", "saved disable one erase", cnt_e, 1);
    ae = 1; cyc(1); ae = 0; cyc(1);
    chk("R10", "auto on live", aen, 1);

    // R11 / R8: power-fail store then low-supply wait ignores everything
    clr_cnt();
    wr = 1; cyc(1); wr = 0;
    vcc = 0; cyc(25);
    sws = 1; wr = 1; ext_low = 1;
    chk("R11", "low supply write blocked", wri, 1);
    cyc(1); sws = 0; wr = 0; cyc(3); ext_low = 0; cyc(2);
    chk("R11", "power-fail store only once", cnt_e, 1);
    chk("R11", "no recall while low", cnt_c, 0);
    vcc = 1; cyc(20);
    chk("R8", "recall after supply return", cnt_c, 1);

    // R12: pin and software store together, grace comes first
    clr_cnt();
    wr = 1; cyc(1); wr = 0;
    ext_low = 1; sws = 1; cyc(1); sws = 0;
    chk("R12", "pin beats software store busy_low", bl, 1);
    chk("R12", "pin beats software store no early erase", cnt_e, 0);
    cyc(2); ext_low = 0; cyc(30);
    chk("R12", "single erase after combined request", cnt_e, 1);

    // R12: store beats recall
    clr_cnt();
    sws = 1; swr = 1; cyc(1); sws = 0; swr = 0; cyc(30);
    chk("R12", "store over recall erase", cnt_e, 1);
    chk("R12", "store over recall clear", cnt_c, 0);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule